// File: doc/BRIEF.md
# Cascaded Nibble Interrupt Timer

This block is an interrupt timer on the cartridge side of a CPU bus. It advances once for each CPU cycle that its clock enable marks. A 7-bit prescaler runs freely. Each time its bit 6 rises, and clock mode is on, the block takes one counting step. The count is held as two 4-bit halves. The low half increments on every step. The high half increments only when the low half has just become 15.

Software loads both halves from one data byte and starts counting by turning clock mode on. When the high half reaches 15, the block raises a level interrupt. The interrupt stays up until software acknowledges it. While the interrupt is pending, the prescaler is held at zero, so counting restarts from a known phase after the acknowledge.

Register writes arrive as a select strobe, two address bits and a data byte. A write takes effect on the clock edge where the strobe is high, whether or not the cycle enable is high.

Top module: `nibble_irq_timer`

## Requirements
- R1: A write with address 0 clears the clock-mode flag. A write with address 2 sets it. A write with address 3 changes no state at all.
- R2: A write with address 1 clears the pending flag. If clock mode is off at that edge, the same write loads the low counter from data[3:0] and the high counter from data[7:4]. If clock mode is on, the counters keep their values.
- R3: On every enabled cycle, the 7-bit prescaler is forced to 0 if pending is set; otherwise it increments and wraps from 127 to 0. It holds its value on cycles that are not enabled.
- R4: A counting step happens only on an enabled cycle where clock mode is on and prescaler bit 6 changes from 0 to 1. Starting from a prescaler of 0, the first step falls on the 64th enabled cycle, and later steps follow every 128 enabled cycles.
- R5: On a step, the low counter increments modulo 16. If its new value is 15, the high counter also increments modulo 16. If the high counter's new value is 15, pending is set. A low counter at 15 steps to 0 and does not carry.
- R6: The irq output equals the pending flag. It stays high across any number of cycles until an address-1 write arrives, and drops on the edge of that write.
- R7: If an address-1 write and a step that would set pending fall on the same edge, pending is clear after that edge. The counters still take the step.
- R8: A synchronous reset clears clock mode, pending, both counters and the prescaler, and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | One pulse per CPU cycle; advances the prescaler |
| wr_sel | input | 1 | Write strobe for the timer's register window |
| wr_addr | input | 2 | Register select (low address bits) |
| wr_data | input | 8 | Write data byte |
| irq | output | 1 | Level interrupt request, high while pending |

## Verification
An acknowledge write and the counting step that would raise pending can land on the same edge. The bench provokes this by loading 14/14, which fires on the very first step. It runs exactly 63 enabled cycles and then places the address-1 write on the 64th. It judges the result by requiring irq to stay low on the next sample, and by requiring that no unexpected interrupt rises later, since the scoreboard holds no entry for one. Separately, a load issued while clock mode is on is checked by confirming that the interrupt arrives on the cycle the earlier load predicts.

// File: rtl/nibble_irq_timer.sv
module nibble_irq_timer (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_en,
  input  logic       wr_sel,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq
);

  logic       mode, pend;
  logic [6:0] presc;
  logic [3:0] lo, hi;

  wire wr_stop = wr_sel && (wr_addr == 2'd0);
  wire wr_ack  = wr_sel && (wr_addr == 2'd1);
  wire wr_run  = wr_sel && (wr_addr == 2'd2);

  wire [6:0] presc_nx = pend ? 7'd0 : presc + 7'd1;
  wire       step     = cyc_en && mode && !presc[6] && presc_nx[6];

  wire [3:0] lo_nx = lo + 4'd1;
  wire       carry = (lo_nx == 4'hF);
  wire [3:0] hi_nx = hi + {3'd0, carry};
  wire       hit   = carry && (hi_nx == 4'hF);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      pend  <= 1'b0;
      presc <= '0;
      lo    <= '0;
      hi    <= '0;
    end else begin
      if (cyc_en) presc <= presc_nx;

      if (wr_stop)     mode <= 1'b0;
      else if (wr_run) mode <= 1'b1;

      if (wr_ack)          pend <= 1'b0;
      else if (step && hit) pend <= 1'b1;

      if (wr_ack && !mode) begin
        lo <= wr_data[3:0];
        hi <= wr_data[7:4];
      end else if (step) begin
        lo <= lo_nx;
        hi <= hi_nx;
      end
    end
  end

  assign irq = pend;

endmodule

module nibble_irq_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc_en,
  input logic       wr_sel,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq,
  input logic       mode,
  input logic [6:0] presc,
  input logic [3:0] lo,
  input logic [3:0] hi
);

  a_r1_addr3_inert: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wr_addr == 2'd3) |=> ($stable(mode) && $stable(lo) && $stable(hi)));

  a_r2_load_when_idle: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wr_addr == 2'd1 && !mode) |=> (lo == $past(wr_data[3:0]) && hi == $past(wr_data[7:4])));

  a_r3_presc_held: assert property (@(posedge clk) disable iff (rst)
    (irq && cyc_en) |=> (presc == 7'd0));

  a_r3_presc_frozen: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(presc));

  a_r5_rise_on_step: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(mode) && $past(presc) == 7'd63 && $past(cyc_en)));

  a_r6_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wr_addr == 2'd1) |=> !irq);

endmodule

bind nibble_irq_timer nibble_irq_timer_chk u_chk (
  .clk(clk), .rst(rst), .cyc_en(cyc_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .mode(mode), .presc(presc), .lo(lo), .hi(hi)
);

// File: tb/sim_nibble_irq_timer.sv
`timescale 1ns/1ps
module sim_nibble_irq_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  nibble_irq_timer u0 (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts enabled edges since cyc_en rose, compares irq rise timing
  int  cnt = 0;
  logic en_p = 1'b0, irq_p = 1'b0;
  always @(negedge clk) begin
    if (cyc_en && !en_p) cnt = 1;
    else if (cyc_en) cnt++;
    en_p = cyc_en;
    if (irq && !irq_p) begin
      if (exp_q.size() == 0) check("R7 unexpected irq", cnt, -1);
      else check(tag_q.pop_front(), cnt, exp_q.pop_front());
    end
    irq_p = irq;
  end

  task automatic do_reset();
    @(negedge clk); #1 rst = 1'b1; cyc_en = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1 wr_sel = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1 wr_sel = 1'b0;
  endtask

  task automatic expect_fire(input string req, input int edges);
    exp_q.push_back(edges);
    tag_q.push_back(req);
  endtask

  task automatic run_until_irq(input int limit);
    @(negedge clk); #1 cyc_en = 1'b1;
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic fire_case(input string req, input logic [3:0] l, input logic [3:0] h, input int edges);
    do_reset();
    wr(2'd1, {h, l});
    wr(2'd2, 8'h00);
    expect_fire(req, edges);
    run_until_irq(edges + 20);
    check({req, " irq reached"}, irq, 1);
    #1 cyc_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R8 irq after reset", irq, 0);

    // R4/R5: steps to fire N, edges = 64 + 128*(N-1)
    fire_case("R4 L14 H14", 4'd14, 4'd14, 64);
    fire_case("R5 L0 H14", 4'd0, 4'd14, 64 + 128*14);
    fire_case("R5 L15 H14 no carry from 15", 4'd15, 4'd14, 64 + 128*15);
    fire_case("R5 L5 H12", 4'd5, 4'd12, 64 + 128*41);

    // R6: held high while cycles run, presc held (R3), ack drops it
    fire_case("R6 setup", 4'd14, 4'd14, 64);
    @(negedge clk); #1 cyc_en = 1'b1;
    repeat (300) @(negedge clk);
    check("R6 irq held", irq, 1);
    #1 cyc_en = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hEE);
    check("R6 irq dropped by ack", irq, 0);
    wr(2'd2, 8'h00);
    expect_fire("R3 prescaler zero after pending", 64);
    run_until_irq(200);
    check("R3 irq after restart", irq, 1);
    #1 cyc_en = 1'b0;

    // R1: address 3 neither loads nor changes mode
    do_reset();
    wr(2'd1, 8'hEE);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    expect_fire("R1 addr3 inert", 64);
    run_until_irq(200);
    #1 cyc_en = 1'b0;

    // R2: load ignored while mode on
    do_reset();
    wr(2'd1, 8'hEE);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    expect_fire("R2 no load with mode on", 64);
    run_until_irq(200);
    #1 cyc_en = 1'b0;

    // R1: address 0 stops counting; presc 200 mod 128 = 72, then 120 to next step
    do_reset();
    wr(2'd1, 8'hEE);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    @(negedge clk); #1 cyc_en = 1'b1;
    repeat (200) @(negedge clk);
    check("R1 mode cleared no irq", irq, 0);
    #1 cyc_en = 1'b0;
    wr(2'd2, 8'h00);
    expect_fire("R1 resume from prescaler 72", 120);
    run_until_irq(300);
    #1 cyc_en = 1'b0;

    // R7: ack on the same edge as the firing step
    do_reset();
    wr(2'd1, 8'hEE);
    wr(2'd2, 8'h00);
    @(negedge clk); #1 cyc_en = 1'b1;
    repeat (63) @(negedge clk);
    #1 wr_sel = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
    @(negedge clk); #1 wr_sel = 1'b0;
    check("R7 ack wins over step", irq, 0);
    repeat (300) @(negedge clk);
    check("R7 still quiet", irq, 0);
    #1 cyc_en = 1'b0;

    // R8: reset mid-pending
    fire_case("R8 setup", 4'd14, 4'd14, 64);
    do_reset();
    @(negedge clk);
    check("R8 irq cleared by reset", irq, 0);

    check("scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule